// File: doc/BRIEF.md
# Redundant Four-Operand Adder with Leading-Digit Sign Estimate

This block adds four signed operands in a fixed number of full-adder levels, whatever the word width. Carries are never rippled across digit positions. Two operands arrive in borrow-save form and two arrive in two's complement. In borrow-save form each digit is a pair of bits, a positive bit and a negative bit, and the digit's value is the positive bit minus the negative bit. The result is produced in the same redundant form, so it needs two bits per digit. The delay from the operands to the sum register is three full-adder levels, built from full adders whose inputs are partly inverted.

A cheap sign estimate is taken from the three most significant result digits alone. An exact sign would need a full carry resolution, and this estimate avoids it. A separate converter subtracts the negative vector from the positive vector. It gives the exact value in two's complement, which a checking environment can use to confirm every sum. The sum and the sign estimate are registered. They load when the input strobe is high and hold otherwise.

Top module: `bs4_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the sum digits, the sign estimate and the converted value all become zero.
- R2: After a rising edge at which `in_valid` is high, the outputs show that cycle's sum: a_pos − a_neg + b_pos − b_neg + c_tc + d_tc. Here a_pos, a_neg, b_pos and b_neg are unsigned vectors, and c_tc and d_tc are signed two's-complement words of W bits.
- R3: At an edge where `in_valid` is low, the sum digits, the sign estimate and the converted value keep their values, even if the operand inputs change.
- R4: The sum has W+3 digits. Digit i is sum_pos[i] − sum_neg[i] and has weight 2^i, and the sum of the weighted digits equals the R2 value.
- R5: The sum is exact at the range limits: all four operands at their largest positive value, and all four at their most negative value.
- R6: `sign_est` is 1 exactly when 4·d(W+2) + 2·d(W+1) + d(W) < 0, where d(k) is output digit k. A zero value of these three digits gives 0, meaning non-negative.
- R7: When the magnitude of the sum is at least 2^W, `sign_est` equals the true sign.
- R8: Different borrow-save encodings of the same operand value give the same converted sum. An example is equal positive and negative vectors, which encode zero.
- R9: With `in_valid` high on consecutive cycles, each sum appears exactly one cycle after its operands, with none skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for the output registers |
| a_pos | input | W | Operand A, positive bits |
| a_neg | input | W | Operand A, negative bits |
| b_pos | input | W | Operand B, positive bits |
| b_neg | input | W | Operand B, negative bits |
| c_tc | input | W | Operand C, two's complement |
| d_tc | input | W | Operand D, two's complement |
| sum_pos | output | W+3 | Registered sum, positive bits |
| sum_neg | output | W+3 | Registered sum, negative bits |
| sign_est | output | 1 | Registered sign estimate from the top three digits (1 = negative) |
| sum_tc | output | W+3 | Exact two's-complement value of the registered sum |

## Verification
The bound checker checks three things on every cycle. It compares the converted sum with the arithmetic total of the previous cycle's operands whenever the strobe was high. It checks that the registers hold while the strobe is low. It checks that the estimated sign is right whenever the sum's magnitude reaches 2^W. Other behaviours depend on the bit pattern of the digits and not just on the value, so only the bench scenarios can show them. These are the leading-digit rule itself, including the case where the three top digits are zero and a small negative sum still reads as non-negative. They also include the equivalence of redundant encodings of one value and the exact totals at both range limits.

// File: rtl/bs4_pkg.sv
package bs4_pkg;
  // Number of full-adder levels in the reduction; sets the output growth.
  localparam int unsigned LEVELS = 3;
  // Leading digits inspected by the sign estimate.
  localparam int unsigned SIGN_DIGITS = 3;
endpackage

// File: rtl/bs4_fa_row.sv
// A row of independent full adders. Inverting Y and/or Z turns the row
// into the mixed-sign cells used by the borrow-save reduction.
module bs4_fa_row #(
  parameter int unsigned N = 8,
  parameter bit INV_Y = 1'b0,
  parameter bit INV_Z = 1'b0
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] s,
  output logic [N-1:0] c
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic yi, zi;
    assign yi   = y[i] ^ INV_Y;
    assign zi   = z[i] ^ INV_Z;
    assign s[i] = x[i] ^ yi ^ zi;
    assign c[i] = (x[i] & yi) | (x[i] & zi) | (yi & zi);
  end
endmodule

// File: rtl/bs4_sign_est.sv
// Sign of the signed-digit value formed by the K leading digits.
module bs4_sign_est #(
  parameter int unsigned K = 3
) (
  input  logic [K-1:0] dig_pos,
  input  logic [K-1:0] dig_neg,
  output logic         negative
);
  int acc;
  always_comb begin
    acc = 0;
    for (int k = 0; k < K; k++) begin
      acc = acc + ((int'(dig_pos[k]) - int'(dig_neg[k])) <<< k);
    end
    negative = (acc < 0);
  end
endmodule

// File: rtl/bs4_to_tc.sv
// Exact conversion of a borrow-save word: positive vector minus negative.
module bs4_to_tc #(
  parameter int unsigned OW = 19
) (
  input  logic [OW-1:0] dig_pos,
  input  logic [OW-1:0] dig_neg,
  output logic [OW-1:0] value
);
  assign value = dig_pos - dig_neg;
endmodule

// File: rtl/bs4_adder.sv
module bs4_adder
  import bs4_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned OW = W + LEVELS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  a_pos,
  input  logic [W-1:0]  a_neg,
  input  logic [W-1:0]  b_pos,
  input  logic [W-1:0]  b_neg,
  input  logic [W-1:0]  c_tc,
  input  logic [W-1:0]  d_tc,
  output logic [OW-1:0] sum_pos,
  output logic [OW-1:0] sum_neg,
  output logic          sign_est,
  output logic [OW-1:0] sum_tc
);
  // The weight of a two's-complement sign bit is negative. Flipping it makes
  // every bit positive and leaves a constant -2^(W-1) per operand. The two
  // constants combine into one negative unit at column W.
  logic [W-1:0] c_adj, d_adj;
  assign c_adj = {~c_tc[W-1], c_tc[W-2:0]};
  assign d_adj = {~d_tc[W-1], d_tc[W-2:0]};

  // Level 1: two (+,+,-) rows over W columns.
  logic [W-1:0] sa, ca, sb, cb;
  bs4_fa_row #(.N(W), .INV_Y(1'b0), .INV_Z(1'b1)) u_l1a (
    .x(a_pos), .y(b_pos), .z(a_neg), .s(sa), .c(ca));
  bs4_fa_row #(.N(W), .INV_Y(1'b0), .INV_Z(1'b1)) u_l1b (
    .x(c_adj), .y(d_adj), .z(b_neg), .s(sb), .c(cb));

  logic [W:0]   l1_pa, l1_pb, l1_na;
  logic [W-1:0] l1_nb;
  assign l1_pa = {ca, 1'b0};
  assign l1_pb = {cb, 1'b0};
  assign l1_na = {1'b1, ~sa};   // top bit: the folded sign-bit constant
  assign l1_nb = ~sb;

  // Level 2: one (+,+,-) row over W+1 columns.
  logic [W:0] s2, c2;
  bs4_fa_row #(.N(W+1), .INV_Y(1'b0), .INV_Z(1'b1)) u_l2 (
    .x(l1_pa), .y(l1_pb), .z(l1_na), .s(s2), .c(c2));

  logic [W+1:0] l2_p, l2_n, l1_nb_x;
  assign l2_p    = {c2, 1'b0};
  assign l2_n    = {1'b0, ~s2};
  assign l1_nb_x = {2'b00, l1_nb};

  // Level 3: one (+,-,-) row over W+2 columns.
  logic [W+1:0] s3, c3;
  bs4_fa_row #(.N(W+2), .INV_Y(1'b1), .INV_Z(1'b1)) u_l3 (
    .x(l2_p), .y(l2_n), .z(l1_nb_x), .s(s3), .c(c3));

  logic [OW-1:0] nxt_pos, nxt_neg;
  assign nxt_pos = {1'b0, s3};
  assign nxt_neg = {~c3, 1'b0};

  logic nxt_sign;
  bs4_sign_est #(.K(SIGN_DIGITS)) u_sign (
    .dig_pos(nxt_pos[OW-1 -: SIGN_DIGITS]),
    .dig_neg(nxt_neg[OW-1 -: SIGN_DIGITS]),
    .negative(nxt_sign));

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_pos  <= '0;
      sum_neg  <= '0;
      sign_est <= 1'b0;
    end else if (in_valid) begin
      sum_pos  <= nxt_pos;
      sum_neg  <= nxt_neg;
      sign_est <= nxt_sign;
    end
  end

  bs4_to_tc #(.OW(OW)) u_conv (
    .dig_pos(sum_pos), .dig_neg(sum_neg), .value(sum_tc));
endmodule

// File: rtl/bs4_adder_chk.sv
module bs4_adder_chk #(
  parameter int unsigned W = 16,
  localparam int unsigned OW = W + 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  a_pos,
  input logic [W-1:0]  a_neg,
  input logic [W-1:0]  b_pos,
  input logic [W-1:0]  b_neg,
  input logic [W-1:0]  c_tc,
  input logic [W-1:0]  d_tc,
  input logic [OW-1:0] sum_pos,
  input logic [OW-1:0] sum_neg,
  input logic          sign_est,
  input logic [OW-1:0] sum_tc
);
  localparam longint BIG = longint'(1) <<< W;

  logic [OW-1:0] in_total;
  always_comb begin
    in_total = OW'(a_pos) - OW'(a_neg) + OW'(b_pos) - OW'(b_neg)
             + {{3{c_tc[W-1]}}, c_tc} + {{3{d_tc[W-1]}}, d_tc};
  end

  longint out_val;
  assign out_val = longint'($signed(sum_tc));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_pos == '0 && sum_neg == '0 && !sign_est && sum_tc == '0));

  p_sum_exact_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (sum_tc == $past(in_total)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_pos) && $stable(sum_neg) && $stable(sign_est)));

  p_big_pos_r7: assert property (@(posedge clk) disable iff (rst)
    (out_val >= BIG) |-> !sign_est);

  p_big_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (out_val <= -BIG) |-> sign_est);
endmodule

bind bs4_adder bs4_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
  .c_tc(c_tc), .d_tc(d_tc),
  .sum_pos(sum_pos), .sum_neg(sum_neg), .sign_est(sign_est), .sum_tc(sum_tc));

// File: tb/bs4_adder_test.sv
module bs4_adder_test;
  localparam int W  = 16;
  localparam int OW = W + 3;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a_pos = '0, a_neg = '0, b_pos = '0, b_neg = '0, c_tc = '0, d_tc = '0;
  logic [OW-1:0] sum_pos, sum_neg, sum_tc;
  logic sign_est;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bs4_adder #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
    .c_tc(c_tc), .d_tc(d_tc),
    .sum_pos(sum_pos), .sum_neg(sum_neg), .sign_est(sign_est), .sum_tc(sum_tc));

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint digits_value();
    longint v = 0;
    for (int i = 0; i < OW; i++)
      v += (longint'(sum_pos[i]) - longint'(sum_neg[i])) <<< i;
    return v;
  endfunction

  function automatic longint rule_sign();
    longint t = 0;
    for (int k = 0; k < 3; k++)
      t += (longint'(sum_pos[OW-3+k]) - longint'(sum_neg[OW-3+k])) <<< k;
    return (t < 0) ? 1 : 0;
  endfunction

  function automatic longint total(input logic [W-1:0] ap, an, bp, bn, c, d);
    return longint'(ap) - longint'(an) + longint'(bp) - longint'(bn)
         + longint'($signed(c)) + longint'($signed(d));
  endfunction

  task automatic drive(input logic [W-1:0] ap, an, bp, bn, c, d);
    a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn; c_tc = c; d_tc = d;
  endtask

  // Full result check at a negedge: converted value, digit weights, sign rule.
  task automatic check_out(input string tag, input longint exp);
    chk({tag, " R2 converted"}, longint'($signed(sum_tc)), exp);
    chk({tag, " R4 digit sum"}, digits_value(), exp);
    chk({tag, " R6 sign rule"}, longint'(sign_est), rule_sign());
  endtask

  task automatic apply(input string tag, input logic [W-1:0] ap, an, bp, bn, c, d);
    @(negedge clk);
    drive(ap, an, bp, bn, c, d);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag, total(ap, an, bp, bn, c, d));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(16'h1234, 16'h0001, 16'h7777, 16'h0, 16'h0100, 16'h8000);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sum_tc", longint'(sum_tc), 0);
    chk("R1 digits", digits_value(), 0);
    chk("R1 sign", longint'(sign_est), 0);
    in_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_basic();
    apply("basic1", 16'd5, 16'd0, 16'd3, 16'd0, 16'd7, 16'hFFFE);
    apply("basic2", 16'd0, 16'd100, 16'd20, 16'd50, 16'hFF00, 16'd9);
    apply("basic3", 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'hF0F0, 16'h8001, 16'h7FFE);
  endtask

  task automatic t_extremes();
    apply("R5 max", 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 16'h7FFF, 16'h7FFF);
    chk("R5 max value", longint'($signed(sum_tc)), 2*65535 + 2*32767);
    chk("R7 max sign", longint'(sign_est), 0);
    apply("R5 min", 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h8000, 16'h8000);
    chk("R5 min value", longint'($signed(sum_tc)), -2*65535 - 65536);
    chk("R7 min sign", longint'(sign_est), 1);
  endtask

  task automatic t_redundant();
    apply("R8 zero", 16'hFFFF, 16'hFFFF, 16'h1234, 16'h1234, 16'h0, 16'h0);
    chk("R8 zero value", longint'($signed(sum_tc)), 0);
    apply("R8 enc1", 16'd10, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0);
    chk("R8 enc1 value", longint'($signed(sum_tc)), 10);
    apply("R8 enc2", 16'hFF0F, 16'hFF05, 16'd4, 16'd4, 16'd0, 16'd0);
    chk("R8 enc2 value", longint'($signed(sum_tc)), 10);
  endtask

  task automatic t_hold();
    logic [OW-1:0] kp, kn, kt;
    logic ks;
    apply("R3 load", 16'd300, 16'd1, 16'd2, 16'd0, 16'hFFF0, 16'd4);
    kp = sum_pos; kn = sum_neg; kt = sum_tc; ks = sign_est;
    for (int i = 0; i < 3; i++) begin
      drive(16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 16'h8000, 16'h7FFF);
      @(negedge clk);
      chk("R3 hold pos", longint'(sum_pos), longint'(kp));
      chk("R3 hold neg", longint'(sum_neg), longint'(kn));
      chk("R3 hold tc", longint'(sum_tc), longint'(kt));
      chk("R3 hold sign", longint'(sign_est), longint'(ks));
    end
  endtask

  task automatic t_stream();
    longint prev;
    logic [W-1:0] ap, an, bp, bn, c, d;
    @(negedge clk);
    prev = 0;
    for (int k = 0; k <= 20; k++) begin
      if (k > 0) check_out("R9 stream", prev);
      ap = W'($urandom); an = W'($urandom); bp = W'($urandom);
      bn = W'($urandom); c = W'($urandom); d = W'($urandom);
      drive(ap, an, bp, bn, c, d);
      prev = total(ap, an, bp, bn, c, d);
      in_valid = (k < 20);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_sign();
    // A sum of -1: its top three digits are zero, so the estimate reads non-negative.
    apply("R6 minus1", 16'd0, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0);
    chk("R6 minus1 sign", longint'(sign_est), 0);
    apply("R7 big neg", 16'd0, 16'hC000, 16'd0, 16'h8000, 16'h8000, 16'h0);
    chk("R7 big neg sign", longint'(sign_est), 1);
    apply("R7 big pos", 16'hC000, 16'd0, 16'hC000, 16'd0, 16'd0, 16'd0);
    chk("R7 big pos sign", longint'(sign_est), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_extremes();
    t_redundant();
    t_hold();
    t_stream();
    t_sign();
    @(negedge clk);
    report();
  end
endmodule